// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Control Registers

This block is the register front end that software uses to drive a modular-exponentiation engine. A simple 32-bit bus with select, write, address and data lets software program five things: where the operand image sits in memory, how long it is, the operand-load mode, the exponent and modulus widths in bits, and which side owns the shared operand memory. One write to the start register launches the job.

The launched job either runs a DMA load followed by a compute pass, or runs a compute pass alone. The block sequences the two phases from strobes returned by the DMA loader and the math core. When the compute finishes, it raises a completion flag. That flag drives an interrupt line through a mask. Software clears the flag by writing ones, and it stops the engine by writing zero to the start register. The block also gates the request lines of the shared operand memory: exactly one side, the CPU bus or the engine, is granted access at a time.

Top module: `rsa_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, no start pulse is issued, and the engine owns the operand memory (`mem_cpu_own` low).
- R2: The base register (0x04C), the length register (0x050) and the key-length register (0x058) keep all 32 bits. In the command register (0x048), only bits [5:4] (load mode) and bit 8 (CPU owns memory) are stored. In the mask register (0x3F8), only bit 1 is stored. Every other bit of these two registers, and every unmapped address, reads zero.
- R3: The key-length register drives `exp_bits` from its bits [31:16] and `mod_bits` from its bits [15:0]. Command bits [5:4] drive `dma_mode` and command bit 8 drives `mem_cpu_own`.
- R4: When idle, a start write with bit 1 set issues a one-cycle `dma_start` in the cycle after the write. A later `dma_done` then issues a one-cycle `core_start` in the cycle after the strobe.
- R5: When idle, a start write with bit 0 set and bit 1 clear issues a one-cycle `core_start` and no `dma_start`.
- R6: The start register (0x000) reads bits [1:0] as zero at all times. It reads bit 2 as one from the cycle after an accepted start until the job ends.
- R7: A `core_done` during the compute phase sets status bit 1 (0x3FC) and ends the job. Writing a one to status bit 1 clears it. Writing a zero there leaves it set.
- R8: `irq` is high exactly when status bit 1 and mask bit 1 are both set.
- R9: Writing a value with bits [1:0] zero to the start register returns the block to idle. Any later done strobe from the aborted job has no effect.
- R10: With command bit 8 set, `cpu_mem_gnt` follows `cpu_mem_req` and `eng_mem_gnt` is low. With bit 8 clear, `eng_mem_gnt` follows `eng_mem_req` and `cpu_mem_gnt` is low.
- R11: A nonzero start write while a job runs is ignored. Done strobes while idle change neither the status nor the start outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| dma_done | input | 1 | DMA loader finished strobe |
| core_done | input | 1 | Math core finished strobe |
| cpu_mem_req | input | 1 | CPU-side operand memory request |
| eng_mem_req | input | 1 | Engine-side operand memory request |
| dma_start | output | 1 | One-cycle DMA launch pulse |
| core_start | output | 1 | One-cycle compute launch pulse |
| dma_mode | output | 2 | Operand-load mode |
| mem_cpu_own | output | 1 | Operand memory assigned to CPU bus |
| dma_base | output | 32 | DMA source base address |
| dma_len | output | 32 | DMA length |
| exp_bits | output | 16 | Exponent width in bits |
| mod_bits | output | 16 | Modulus width in bits |
| cpu_mem_gnt | output | 1 | CPU memory access granted |
| eng_mem_gnt | output | 1 | Engine memory access granted |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer state shows up at the ports within one cycle in two ways. The busy bit in the start register disagrees with the job phase, or a start pulse appears or goes missing right after the write or the strobe that should have caused it. A stuck or lost completion flag shows on `irq` and on the status read in the cycle after `core_done` or after the clearing write. A wrong stored bit in a configuration register is exposed by the walking-one sweep on the very next read, and on the matching output field. A wrong ownership bit appears at once as swapped or doubled grants.

// File: rtl/rsa_ctrl_regs.sv
module rsa_ctrl_regs #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dma_done,
  input  logic          core_done,
  input  logic          cpu_mem_req,
  input  logic          eng_mem_req,
  output logic          dma_start,
  output logic          core_start,
  output logic [1:0]    dma_mode,
  output logic          mem_cpu_own,
  output logic [DW-1:0] dma_base,
  output logic [DW-1:0] dma_len,
  output logic [DW/2-1:0] exp_bits,
  output logic [DW/2-1:0] mod_bits,
  output logic          cpu_mem_gnt,
  output logic          eng_mem_gnt,
  output logic          irq
);
  localparam logic [AW-1:0] A_GO   = AW'(12'h000);
  localparam logic [AW-1:0] A_CMD  = AW'(12'h048);
  localparam logic [AW-1:0] A_BASE = AW'(12'h04C);
  localparam logic [AW-1:0] A_LEN  = AW'(12'h050);
  localparam logic [AW-1:0] A_KLEN = AW'(12'h058);
  localparam logic [AW-1:0] A_MSK  = AW'(12'h3F8);
  localparam logic [AW-1:0] A_STS  = AW'(12'h3FC);

  typedef enum logic [1:0] {IDLE, LOAD, CALC} st_t;
  st_t st;

  logic [DW-1:0] base_q, len_q, klen_q;
  logic [1:0]    mode_q;
  logic          own_q, msk_q, sts_q, dma_go_q, core_go_q;

  logic wr_en, wr_go, stop, busy, fin;
  assign wr_en = bus_sel & bus_wr;
  assign wr_go = wr_en && (bus_addr == A_GO);
  assign stop  = wr_go && (bus_wdata[1:0] == 2'b00);
  assign busy  = (st != IDLE);
  assign fin   = (st == CALC) && core_done && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; dma_go_q <= 1'b0; core_go_q <= 1'b0;
    end else begin
      dma_go_q  <= 1'b0;
      core_go_q <= 1'b0;
      case (st)
        IDLE: if (wr_go && bus_wdata[1]) begin
                st <= LOAD; dma_go_q <= 1'b1;
              end else if (wr_go && bus_wdata[0]) begin
                st <= CALC; core_go_q <= 1'b1;
              end
        LOAD: if (stop) st <= IDLE;
              else if (dma_done) begin st <= CALC; core_go_q <= 1'b1; end
        CALC: if (stop || core_done) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; len_q <= '0; klen_q <= '0;
      mode_q <= '0; own_q <= 1'b0; msk_q <= 1'b0; sts_q <= 1'b0;
    end else begin
      if (wr_en && bus_addr == A_CMD) begin
        mode_q <= bus_wdata[5:4];
        own_q  <= bus_wdata[8];
      end
      if (wr_en && bus_addr == A_BASE) base_q <= bus_wdata;
      if (wr_en && bus_addr == A_LEN)  len_q  <= bus_wdata;
      if (wr_en && bus_addr == A_KLEN) klen_q <= bus_wdata;
      if (wr_en && bus_addr == A_MSK)  msk_q  <= bus_wdata[1];
      sts_q <= (sts_q & ~(wr_en && bus_addr == A_STS && bus_wdata[1])) | fin;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_GO:   bus_rdata[2] = busy;
        A_CMD:  begin bus_rdata[5:4] = mode_q; bus_rdata[8] = own_q; end
        A_BASE: bus_rdata = base_q;
        A_LEN:  bus_rdata = len_q;
        A_KLEN: bus_rdata = klen_q;
        A_MSK:  bus_rdata[1] = msk_q;
        A_STS:  bus_rdata[1] = sts_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign dma_start   = dma_go_q;
  assign core_start  = core_go_q;
  assign dma_mode    = mode_q;
  assign mem_cpu_own = own_q;
  assign dma_base    = base_q;
  assign dma_len     = len_q;
  assign exp_bits    = klen_q[DW-1:DW/2];
  assign mod_bits    = klen_q[DW/2-1:0];
  assign cpu_mem_gnt = own_q & cpu_mem_req;
  assign eng_mem_gnt = ~own_q & eng_mem_req;
  assign irq         = sts_q & msk_q;

  // R4
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);
  // R4
  dma_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (st == LOAD));
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == CALC) && core_done && !stop) |=> (sts_q && st == IDLE));
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> msk_q);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == IDLE && !core_start));
  // R10
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_mem_gnt && eng_mem_gnt));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == IDLE) && !wr_go) |=> (!core_start && !dma_start && $stable(sts_q) || !sts_q));
endmodule

// File: tb/tb_rsa_ctrl_regs.sv
module tb_rsa_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_GO = 12'h000, A_CMD = 12'h048, A_BASE = 12'h04C,
                          A_LEN = 12'h050, A_KLEN = 12'h058, A_MSK = 12'h3F8,
                          A_STS = 12'h3FC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dma_done = 1'b0, core_done = 1'b0, cpu_mem_req = 1'b0, eng_mem_req = 1'b0;
  logic dma_start, core_start, mem_cpu_own, cpu_mem_gnt, eng_mem_gnt, irq;
  logic [1:0] dma_mode;
  logic [31:0] dma_base, dma_len;
  logic [15:0] exp_bits, mod_bits;

  int n_cmp = 0, n_bad = 0;
  logic saw_dma, saw_core;
  logic [31:0] rd;

  rsa_ctrl_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    saw_dma = dma_start; saw_core = core_start;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic strobe(input bit is_core);
    @(negedge clk);
    if (is_core) core_done = 1'b1; else dma_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0; dma_done = 1'b0;
    saw_dma = dma_start; saw_core = core_start;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] regs [5];
    logic [31:0] keep [5];
    regs = '{A_CMD, A_BASE, A_LEN, A_KLEN, A_MSK};
    keep = '{32'h0000_0130, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0002};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (regs[k]) begin brd(regs[k], rd); chk("R1 reg", rd, 32'h0); end
    brd(A_GO, rd);  chk("R1 go", rd, 32'h0);
    brd(A_STS, rd); chk("R1 sts", rd, 32'h0);
    chk("R1 irq/own/starts", {irq, mem_cpu_own, dma_start, core_start}, 32'h0);

    // R2 walking-one sweep over every data register
    foreach (regs[k])
      for (int i = 0; i < 32; i++) begin
        bwr(regs[k], 32'h1 << i);
        brd(regs[k], rd);
        chk("R2 walk", rd, (32'h1 << i) & keep[k]);
      end
    brd(12'h100, rd); chk("R2 unmapped", rd, 32'h0);

    // R3 output fields
    for (int e = 0; e < 4; e++) begin
      bwr(A_KLEN, {16'(17 << e), 16'(512 << e)});
      chk("R3 exp_bits", 32'(exp_bits), 32'(17 << e));
      chk("R3 mod_bits", 32'(mod_bits), 32'(512 << e));
    end
    bwr(A_BASE, 32'h8000_1000); chk("R3 base", dma_base, 32'h8000_1000);
    bwr(A_LEN, 32'h1800);       chk("R3 len", dma_len, 32'h1800);
    for (int m = 0; m < 4; m++) begin
      bwr(A_CMD, 32'(m << 4));
      chk("R3 mode", 32'(dma_mode), 32'(m));
    end

    // R10 ownership x request sweep
    for (int v = 0; v < 8; v++) begin
      bwr(A_CMD, {23'b0, v[2], 8'h30});
      @(negedge clk); cpu_mem_req = v[0]; eng_mem_req = v[1]; #1;
      chk("R10 own", 32'(mem_cpu_own), 32'(v[2]));
      chk("R10 grants", {30'b0, cpu_mem_gnt, eng_mem_gnt},
          {30'b0, v[2] & v[0], ~v[2] & v[1]});
    end
    cpu_mem_req = 1'b0; eng_mem_req = 1'b0;
    bwr(A_CMD, 32'h30);

    // R11 done strobes while idle
    strobe(1'b1); chk("R11 idle core_done start", {saw_dma, saw_core}, 32'h0);
    strobe(1'b0); chk("R11 idle dma_done start", {saw_dma, saw_core}, 32'h0);
    brd(A_STS, rd); chk("R11 idle sts", rd, 32'h0);

    // R4 full sequence, R6 busy, R11 start while busy
    bwr(A_MSK, 32'h2);
    bwr(A_GO, 32'h3);
    chk("R4 dma_start pulse", {saw_dma, saw_core}, 32'h2);
    @(negedge clk); chk("R4 dma_start width", 32'(dma_start), 32'h0);
    brd(A_GO, rd); chk("R6 busy load", rd, 32'h4);
    bwr(A_GO, 32'h1);
    chk("R11 start while busy", {saw_dma, saw_core}, 32'h0);
    strobe(1'b0);
    chk("R4 core_start after dma_done", {saw_dma, saw_core}, 32'h1);
    @(negedge clk); chk("R4 core_start width", 32'(core_start), 32'h0);
    brd(A_GO, rd); chk("R6 busy calc", rd, 32'h4);
    chk("R8 irq before done", 32'(irq), 32'h0);
    strobe(1'b1);
    brd(A_STS, rd); chk("R7 sts set", rd, 32'h2);
    chk("R8 irq asserted", 32'(irq), 32'h1);
    brd(A_GO, rd); chk("R6 idle after done", rd, 32'h0);

    // R8 mask gating, R7 write-zero keeps, write-one clears
    bwr(A_MSK, 32'h0); chk("R8 irq masked", 32'(irq), 32'h0);
    bwr(A_MSK, 32'h2); chk("R8 irq unmasked", 32'(irq), 32'h1);
    bwr(A_STS, 32'hFFFF_FFFD); brd(A_STS, rd); chk("R7 write zero keeps", rd, 32'h2);
    bwr(A_STS, 32'h2); brd(A_STS, rd); chk("R7 w1c", rd, 32'h0);
    chk("R8 irq cleared", 32'(irq), 32'h0);

    // R5 compute-only start
    bwr(A_GO, 32'h1);
    chk("R5 core only", {saw_dma, saw_core}, 32'h1);
    brd(A_GO, rd); chk("R6 busy core only", rd, 32'h4);
    strobe(1'b1);
    brd(A_STS, rd); chk("R5 sts after core only", rd, 32'h2);
    bwr(A_STS, 32'h2);

    // R9 stop during load, then stale strobes
    bwr(A_GO, 32'h3);
    bwr(A_GO, 32'h0);
    brd(A_GO, rd); chk("R9 idle after stop", rd, 32'h0);
    strobe(1'b0); chk("R9 stale dma_done", {saw_dma, saw_core}, 32'h0);
    strobe(1'b1); brd(A_STS, rd); chk("R9 stale core_done", rd, 32'h0);

    // R9 stop during compute
    bwr(A_GO, 32'h1);
    bwr(A_GO, 32'h0);
    brd(A_GO, rd); chk("R9 idle after stop calc", rd, 32'h0);
    strobe(1'b1); brd(A_STS, rd); chk("R9 no flag after stop", rd, 32'h0);
    chk("R9 irq low", 32'(irq), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule